// File: doc/BRIEF.md
# Lagging-Core Store Commit Checker

This block couples two cores that run one instruction stream, the trailing core some number of instructions behind the leading core. Each load, branch and store event of the leading core enters a single in-order queue. The trailing core reads its load values from that queue, so it never reads memory itself. Each trailing event is compared with the queue head. A store goes to memory only after the trailing core has produced the same address and data.

The leading core is stalled while the queue is full, so the queue depth sets the maximum lag. On the first disagreement the block raises a sticky error and drops every queued event, so no unconfirmed store can reach memory. Stores that were confirmed before the error still drain to memory. Memory writes leave the block through a valid/ready port, one per cycle.

Event kind encoding on both event inputs: 2'd0 load, 2'd1 branch, 2'd2 store. For a branch, the address field carries the branch location and the data field carries the outcome.

Top module: `lag_commit_checker`

## Requirements
- R1: After reset, error_o, trail_ready_o and mem_valid_o are low and lead_ready_o is high.
- R2: Leading events are queued in arrival order. Once DEPTH events are held, lead_ready_o is low, and an event offered while it is low is not stored.
- R3: trail_ready_o is high only when the queue holds an event, no error is set and the commit buffer has room. Trailing events are matched against leading events in leading order.
- R4: While the queue head is a load (kind 0), trail_load_data_o carries that load's data. The trailing load address must equal the queued address. The trailing data field of a load is ignored.
- R5: A trailing branch (kind 1) matches only if both its address and its outcome (data field) equal the queued branch.
- R6: A trailing store (kind 2) whose address and data equal the queued store is committed. It appears on mem_valid_o/mem_addr_o/mem_data_o in the cycle after its acceptance.
- R7: A store the leading core has queued never appears on the memory port before the trailing core has confirmed it.
- R8: While mem_valid_o is high and mem_ready_i is low, mem_valid_o, mem_addr_o and mem_data_o hold. Committed stores leave one per accepted cycle, in commit order.
- R9: A trailing event whose kind differs from the queue head kind is a mismatch.
- R10: On any mismatch the head is not committed and error_o rises in the next cycle. The queue is emptied at the same edge. lead_ready_o and trail_ready_o then stay low until reset. Stores confirmed earlier still drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lead_valid_i | input | 1 | Leading event offered |
| lead_kind_i | input | 2 | Leading event kind |
| lead_addr_i | input | AW | Leading address (load/store address, branch location) |
| lead_data_i | input | DW | Load value, store data or branch outcome |
| lead_ready_o | output | 1 | Queue can take a leading event |
| trail_valid_i | input | 1 | Trailing event offered |
| trail_kind_i | input | 2 | Trailing event kind |
| trail_addr_i | input | AW | Trailing address |
| trail_data_i | input | DW | Trailing store data or branch outcome |
| trail_ready_o | output | 1 | Trailing event can be accepted |
| trail_load_data_o | output | DW | Load value for the trailing core |
| mem_valid_o | output | 1 | Committed store available |
| mem_addr_o | output | AW | Store address |
| mem_data_o | output | DW | Store data |
| mem_ready_i | input | 1 | Memory takes the store |
| error_o | output | 1 | Sticky mismatch flag |

## Verification
The ready outputs and the forwarded load value depend only on registered state, so they are valid in the same cycle as the stimulus. A confirmed store shows on the memory port in the cycle after the accepting edge. error_o and the emptied queue also show in the cycle after the mismatching edge. The bench drives inputs on the falling edge and lets one rising edge pass. It samples on the next falling edge, which is the first point at which each of these registered results is due.

// File: rtl/lcc_pkg.sv
package lcc_pkg;
  typedef enum logic [1:0] {
    EV_LOAD   = 2'd0,
    EV_BRANCH = 2'd1,
    EV_STORE  = 2'd2,
    EV_RSVD   = 2'd3
  } ev_kind_e;
endpackage

// File: rtl/lcc_fifo.sv
module lcc_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] slot_q [DEPTH];
  logic [PW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign data_o  = slot_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) slot_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= bump(wr_q);
      if (pop_i)  rd_q <= bump(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_underflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/lcc_match.sv
module lcc_match
  import lcc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic [1:0]    head_kind_i,
  input  logic [AW-1:0] head_addr_i,
  input  logic [DW-1:0] head_data_i,
  input  logic [1:0]    tr_kind_i,
  input  logic [AW-1:0] tr_addr_i,
  input  logic [DW-1:0] tr_data_i,
  output logic          match_o
);
  logic kind_eq, addr_eq, data_eq, is_load;

  assign kind_eq = (head_kind_i == tr_kind_i);
  assign addr_eq = (head_addr_i == tr_addr_i);
  assign data_eq = (head_data_i == tr_data_i);
  assign is_load = (head_kind_i == EV_LOAD);
  // load data comes from the queue, so only its address is compared
  assign match_o = kind_eq && addr_eq && (is_load || data_eq);
endmodule

// File: rtl/lag_commit_checker.sv
module lag_commit_checker
  import lcc_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int DEPTH  = 8,
  parameter int CDEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lead_valid_i,
  input  logic [1:0]    lead_kind_i,
  input  logic [AW-1:0] lead_addr_i,
  input  logic [DW-1:0] lead_data_i,
  output logic          lead_ready_o,
  input  logic          trail_valid_i,
  input  logic [1:0]    trail_kind_i,
  input  logic [AW-1:0] trail_addr_i,
  input  logic [DW-1:0] trail_data_i,
  output logic          trail_ready_o,
  output logic [DW-1:0] trail_load_data_o,
  output logic          mem_valid_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_data_o,
  input  logic          mem_ready_i,
  output logic          error_o
);
  localparam int EW = 2 + AW + DW;
  localparam int SW = AW + DW;

  logic [EW-1:0] ev_head;
  logic [1:0]    head_kind;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data;
  logic          ev_full, ev_empty, ev_push, ev_pop, ev_flush;
  logic          cm_full, cm_empty, cm_push, cm_pop;
  logic [SW-1:0] cm_head;
  logic          match, trail_fire, err_q;

  assign {head_kind, head_addr, head_data} = ev_head;

  assign lead_ready_o  = !ev_full && !err_q;
  assign ev_push       = lead_valid_i && lead_ready_o;
  assign trail_ready_o = !ev_empty && !err_q && !cm_full;
  assign trail_fire    = trail_valid_i && trail_ready_o;
  assign ev_pop        = trail_fire && match;
  assign ev_flush      = trail_fire && !match;
  assign cm_push       = ev_pop && (head_kind == EV_STORE);
  assign cm_pop        = mem_valid_o && mem_ready_i;

  assign trail_load_data_o = (!ev_empty && head_kind == EV_LOAD) ? head_data : '0;
  assign mem_valid_o       = !cm_empty;
  assign {mem_addr_o, mem_data_o} = cm_head;
  assign error_o           = err_q;

  lcc_fifo #(.WIDTH(EW), .DEPTH(DEPTH)) u_event_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (ev_flush),
    .push_i  (ev_push),
    .data_i  ({lead_kind_i, lead_addr_i, lead_data_i}),
    .pop_i   (ev_pop),
    .data_o  (ev_head),
    .full_o  (ev_full),
    .empty_o (ev_empty)
  );

  lcc_match #(.AW(AW), .DW(DW)) u_match (
    .head_kind_i (head_kind),
    .head_addr_i (head_addr),
    .head_data_i (head_data),
    .tr_kind_i   (trail_kind_i),
    .tr_addr_i   (trail_addr_i),
    .tr_data_i   (trail_data_i),
    .match_o     (match)
  );

  // confirmed stores only; never flushed
  lcc_fifo #(.WIDTH(SW), .DEPTH(CDEPTH)) u_commit_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (1'b0),
    .push_i  (cm_push),
    .data_i  ({head_addr, head_data}),
    .pop_i   (cm_pop),
    .data_o  (cm_head),
    .full_o  (cm_full),
    .empty_o (cm_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       err_q <= 1'b0;
    else if (ev_flush) err_q <= 1'b1;
  end

  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  assert_err_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> (!lead_ready_o && !trail_ready_o));
  assert_err_no_commit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(!cm_push));
  assert_mem_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o)));
  assert_commit_confirmed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cm_push |-> (trail_valid_i && trail_kind_i == EV_STORE && trail_addr_i == head_addr));
endmodule

// File: tb/lag_commit_checker_test.sv
module lag_commit_checker_test;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int DEPTH = 8;
  localparam int NV = 8;

  // {kind, addr, data}
  localparam logic [65:0] VEC [NV] = '{
    {2'd0, 32'h0000_1000, 32'hA5A5_0001},
    {2'd2, 32'h0000_2000, 32'h1111_2222},
    {2'd1, 32'h0000_0040, 32'h0000_0001},
    {2'd0, 32'h0000_1004, 32'h5A5A_0002},
    {2'd2, 32'h0000_2004, 32'h3333_4444},
    {2'd1, 32'h0000_0080, 32'h0000_0000},
    {2'd2, 32'h0000_2008, 32'hDEAD_BEEF},
    {2'd0, 32'h0000_1008, 32'h0BAD_F00D}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic lead_valid_i = 1'b0, trail_valid_i = 1'b0, mem_ready_i = 1'b0;
  logic [1:0] lead_kind_i = '0, trail_kind_i = '0;
  logic [AW-1:0] lead_addr_i = '0, trail_addr_i = '0;
  logic [DW-1:0] lead_data_i = '0, trail_data_i = '0;
  logic lead_ready_o, trail_ready_o, mem_valid_o, error_o;
  logic [DW-1:0] trail_load_data_o, mem_data_o;
  logic [AW-1:0] mem_addr_o;
  int n_checks = 0, n_fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lag_commit_checker #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .CDEPTH(4)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .lead_valid_i(lead_valid_i), .lead_kind_i(lead_kind_i), .lead_addr_i(lead_addr_i),
    .lead_data_i(lead_data_i), .lead_ready_o(lead_ready_o),
    .trail_valid_i(trail_valid_i), .trail_kind_i(trail_kind_i), .trail_addr_i(trail_addr_i),
    .trail_data_i(trail_data_i), .trail_ready_o(trail_ready_o),
    .trail_load_data_o(trail_load_data_o),
    .mem_valid_o(mem_valid_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
    .mem_ready_i(mem_ready_i), .error_o(error_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; lead_valid_i = 0; trail_valid_i = 0; mem_ready_i = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic lead(input logic [1:0] k, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    lead_valid_i = 1; lead_kind_i = k; lead_addr_i = a; lead_data_i = d;
    @(posedge clk);
    @(negedge clk);
    lead_valid_i = 0;
  endtask

  // leaves caller at the negedge after the accepting edge
  task automatic trail(input logic [1:0] k, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    trail_valid_i = 1; trail_kind_i = k; trail_addr_i = a; trail_data_i = d;
    @(posedge clk);
    @(negedge clk);
    trail_valid_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check(!error_o && !trail_ready_o && !mem_valid_o && lead_ready_o, "R1 reset outputs",
          {error_o, trail_ready_o, mem_valid_o, lead_ready_o}, 4'b0001);
    rst_ni = 1'b1;

    // table: fill queue, then trail in order
    mem_ready_i = 1;
    for (int i = 0; i < NV; i++) lead(VEC[i][65:64], VEC[i][63:32], VEC[i][31:0]);
    check(!lead_ready_o, "R2 stall when full", lead_ready_o, 0);
    check(!mem_valid_o, "R7 no store before confirm", mem_valid_o, 0);
    lead(2'd2, 32'hFFFF_0000, 32'h1);  // offered while full: dropped
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      check(trail_ready_o, "R3 trail ready with events", trail_ready_o, 1);
      if (VEC[i][65:64] == 2'd0)
        check(trail_load_data_o == VEC[i][31:0], "R4 load value forwarded",
              trail_load_data_o, VEC[i][31:0]);
      // load data field differs on purpose: ignored
      trail(VEC[i][65:64], VEC[i][63:32], (VEC[i][65:64] == 2'd0) ? ~VEC[i][31:0] : VEC[i][31:0]);
      if (VEC[i][65:64] == 2'd2)
        check(mem_valid_o && mem_addr_o == VEC[i][63:32] && mem_data_o == VEC[i][31:0],
              "R6 store issued next cycle", {mem_addr_o, mem_data_o}, VEC[i][63:0]);
      else if (VEC[i][65:64] == 2'd1)
        check(!error_o, "R5 matching branch accepted", error_o, 0);
      else
        check(!error_o, "R4 load data ignored", error_o, 0);
    end
    check(!trail_ready_o && !error_o, "R2 R3 overflow event not stored",
          {trail_ready_o, error_o}, 0);

    // R7/R8 hold and ordering
    do_reset();
    lead(2'd2, 32'h100, 32'h55);
    lead(2'd2, 32'h104, 32'h66);
    repeat (3) @(negedge clk);
    check(!mem_valid_o, "R7 unconfirmed store held back", mem_valid_o, 0);
    trail(2'd2, 32'h100, 32'h55);
    trail(2'd2, 32'h104, 32'h66);
    repeat (2) @(negedge clk);
    check(mem_valid_o && mem_addr_o == 32'h100 && mem_data_o == 32'h55, "R8 hold while not ready",
          {mem_addr_o, mem_data_o}, {32'h100, 32'h55});
    mem_ready_i = 1;
    @(negedge clk);
    check(mem_valid_o && mem_addr_o == 32'h104 && mem_data_o == 32'h66, "R8 second store in order",
          {mem_addr_o, mem_data_o}, {32'h104, 32'h66});
    @(negedge clk);
    check(!mem_valid_o, "R8 one per cycle drained", mem_valid_o, 0);

    // R3 commit buffer full blocks trailing
    do_reset();
    for (int i = 0; i < 5; i++) lead(2'd2, 32'h300 + 32'(i), 32'(i));
    for (int i = 0; i < 4; i++) trail(2'd2, 32'h300 + 32'(i), 32'(i));
    check(!trail_ready_o, "R3 blocked by full commit buffer", trail_ready_o, 0);
    mem_ready_i = 1;
    @(negedge clk);
    check(trail_ready_o, "R3 resumes after drain", trail_ready_o, 1);

    // R10 store data mismatch after a confirmed store
    do_reset();
    lead(2'd2, 32'h10, 32'h1);
    lead(2'd2, 32'h20, 32'h2);
    lead(2'd0, 32'h30, 32'h3);
    trail(2'd2, 32'h10, 32'h1);
    trail(2'd2, 32'h20, 32'h9);
    check(error_o, "R10 error after store mismatch", error_o, 1);
    check(!lead_ready_o && !trail_ready_o, "R10 queue flushed and blocked",
          {lead_ready_o, trail_ready_o}, 0);
    check(mem_valid_o && mem_addr_o == 32'h10, "R10 earlier store drains", mem_addr_o, 32'h10);
    mem_ready_i = 1;
    repeat (3) @(negedge clk);
    check(!mem_valid_o && error_o, "R10 bad store never issued", {mem_valid_o, error_o}, 2'b01);

    // R9 kind mismatch
    do_reset();
    lead(2'd0, 32'h50, 32'h7);
    trail(2'd1, 32'h50, 32'h7);
    check(error_o, "R9 kind mismatch", error_o, 1);

    // R5 branch outcome mismatch
    do_reset();
    lead(2'd1, 32'h40, 32'h1);
    trail(2'd1, 32'h40, 32'h0);
    check(error_o, "R5 branch outcome mismatch", error_o, 1);

    // R4 load address mismatch
    do_reset();
    lead(2'd0, 32'h80, 32'h12);
    trail(2'd0, 32'h84, 32'h12);
    check(error_o && !trail_ready_o, "R4 load address mismatch", error_o, 1);

    // R6 store address mismatch
    do_reset();
    mem_ready_i = 1;
    lead(2'd2, 32'h90, 32'h5);
    trail(2'd2, 32'h94, 32'h5);
    check(error_o && !mem_valid_o, "R6 store address mismatch", {error_o, mem_valid_o}, 2'b10);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule